// File: doc/BRIEF.md
# Single-Step Trap Sequencer

This block gives a small 16-bit processor hardware single-stepping. It owns the flags word and the stack pointer. At every instruction boundary it decides whether the instruction that now finishes must be followed by a step trap. A trap is due when the trap bit, bit 8 of the flags word, was set at the moment that instruction began. On a trap the block pushes the flags word and then the return address onto a downward-growing memory stack. It clears the trap bit and fetches the handler address from the second entry of a vector table. It then tells the core where to continue.

The block also carries out the interrupt return for the core. On a return request it pops the return address and then the flags word, in the reverse of the push order, and restores both. When the restored flags carry the trap bit, exactly one instruction of the interrupted program runs before the next trap. Software can change the trap bit in only two ways: a full load of the flags word, or the clearing that happens on trap entry.

The controller has eight states. IDLE waits for a boundary or a return. PUSH_FLAGS writes the flags word. PUSH_RET writes the return address. VEC_READ issues the vector read. VEC_TAKE redirects the core to the handler. POP_RET reads the return address. POP_FLAGS reads the saved flags. POP_TAKE restores the flags and redirects the core.

The transitions are:
- IDLE to POP_RET on a return request.
- IDLE to PUSH_FLAGS on a boundary that finds the block armed.
- PUSH_FLAGS to PUSH_RET, then VEC_READ, then VEC_TAKE, then back to IDLE.
- POP_RET to POP_FLAGS, then POP_TAKE, then back to IDLE.

Every non-IDLE state raises busy. While busy is high the core must hold back its next boundary.

Top module: `step_trap_seq`

## Requirements
- R1: After reset the flags word reads 0x0000 and the stack pointer reads SP_RESET (0x0100). Busy, both memory strobes and redirect are all low.
- R2: A boundary strobe (insn_done) in IDLE, with no return request, starts trap entry when the trap bit was set at the start of the finishing instruction. In the next cycle the flags word is written at SP-2. In the cycle after that, next_pc is written at SP-4. The stack pointer ends at SP-4.
- R3: Trap entry clears the trap bit once the flags word has been pushed. Boundaries inside the handler therefore start no trap while the bit stays clear.
- R4: The third cycle after the accepting boundary reads the word at byte address 4 (table base 0, entry 1, 4 bytes per entry). The fourth cycle pulses redirect for one cycle, with redirect_pc equal to that word. Busy is high for exactly those four cycles.
- R5: A return request in IDLE reads the return address at SP in the next cycle, then the saved flags at SP+2. The third cycle pulses redirect with the popped return address. After it the flags word equals the popped word with reserved bits cleared, and the stack pointer is SP+4.
- R6: When a return restores a set trap bit, the very first boundary after the return starts a trap, so exactly one instruction runs between the two traps.
- R7: A flags load (flags_ld) in IDLE replaces the whole flags word. Reserved bits 1, 3, 5 and 12–15 are forced to 0. The new trap bit counts only for instructions that begin after the loading instruction ends: the boundary of the loading instruction itself traps, or does not, according to the old bit. A load on the boundary cycle belongs to the instruction that is finishing.
- R8: While busy, insn_done, ret_req and flags_ld have no effect on the flags word, the stack pointer or the sequence.
- R9: When ret_req and insn_done arrive in the same IDLE cycle, the return is taken and no trap starts, even when armed.
- R10: The block issues at most one memory access per cycle and none in IDLE. Read data is taken in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has finished (boundary strobe) |
| next_pc | input | 16 | Address of the next instruction, valid with insn_done |
| ret_req | input | 1 | Interrupt-return instruction requests the pop sequence |
| flags_ld | input | 1 | Full load of the flags word |
| flags_din | input | 16 | Value for the flags load |
| flags_q | output | 16 | Current flags word |
| sp_q | output | 16 | Current stack pointer (byte address) |
| busy | output | 1 | Entry or return sequence in progress; core holds its boundary |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address (word aligned) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_rd |
| redirect | output | 1 | One-cycle pulse: continue execution at redirect_pc |
| redirect_pc | output | 16 | Handler or return address |

## Verification
The hardest case to reach is a trap bit that changes in the middle of the flow. One instance is a trap bit that a return restores and that must fire on the very next boundary. Another is a trap bit that is loaded or cleared during an instruction that was already armed when it began. From the ports neither case can be set up directly. The stimulus therefore runs a real round trip. It loads the flags in the middle of an instruction and traps. It then returns with the saved bit set. It then returns while a boundary arrives in the same cycle, and finally clears the bit during an armed instruction. A behavioural model that holds the stack contents follows the round trip and predicts every cycle. The bench pulses all three inputs during busy windows, so the model shows that they are ignored.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;
    localparam int WORD_W = 16;
    localparam int TF_POS = 8;
    localparam logic [WORD_W-1:0] FLAG_KEEP = 16'h0FD5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_FLAGS,
        ST_PUSH_RET,
        ST_VEC_READ,
        ST_VEC_TAKE,
        ST_POP_RET,
        ST_POP_FLAGS,
        ST_POP_TAKE
    } seq_state_t;
endpackage

// File: rtl/tss_stack_ptr.sv
module tss_stack_ptr
    import step_trap_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_RESET   = 16'h0100,
    parameter int                WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [WORD_W-1:0] sp_q
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n)   sp_q <= SP_RESET;
        else if (dec) sp_q <= sp_q - STEP;
        else if (inc) sp_q <= sp_q + STEP;
    end
endmodule

// File: rtl/tss_flags.sv
module tss_flags
    import step_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              ld,
    input  logic [WORD_W-1:0] din,
    input  logic              tf_clear,
    input  logic              restore,
    input  logic [WORD_W-1:0] restore_val,
    input  logic              arm_sample,
    output logic [WORD_W-1:0] flags_q,
    output logic              armed
);
    logic [WORD_W-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (restore)
            flags_d = restore_val & FLAG_KEEP;
        else if (tf_clear)
            flags_d[TF_POS] = 1'b0;
        else if (ld && idle)
            flags_d = din & FLAG_KEEP;
    end

    // The armed bit is the trap bit seen as the next instruction begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            if (arm_sample) armed <= flags_d[TF_POS];
        end
    end
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
    import step_trap_pkg::*;
#(
    parameter logic [WORD_W-1:0] VEC_ADDR   = 16'd4,
    parameter int                WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              ret_req,
    input  logic              armed,
    input  logic [WORD_W-1:0] next_pc,
    input  logic [WORD_W-1:0] flags_q,
    input  logic [WORD_W-1:0] sp_q,
    input  logic [WORD_W-1:0] mem_rdata,
    output seq_state_t        state_o,
    output logic              busy,
    output logic              idle,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              sp_dec,
    output logic              sp_inc,
    output logic              tf_clear,
    output logic              fl_restore,
    output logic              arm_sample,
    output logic              redirect,
    output logic [WORD_W-1:0] redirect_pc
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] ret_pc;
    logic              take_trap;

    assign take_trap = (state_q == ST_IDLE) && insn_done && !ret_req && armed;
    assign state_o   = state_q;

    // State register and the latched return address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_pc  <= '0;
        end else begin
            state_q <= state_d;
            if (take_trap)                    ret_pc <= next_pc;
            else if (state_q == ST_POP_FLAGS) ret_pc <= mem_rdata;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_req)        state_d = ST_POP_RET;
                else if (take_trap) state_d = ST_PUSH_FLAGS;
            end
            ST_PUSH_FLAGS: state_d = ST_PUSH_RET;
            ST_PUSH_RET:   state_d = ST_VEC_READ;
            ST_VEC_READ:   state_d = ST_VEC_TAKE;
            ST_VEC_TAKE:   state_d = ST_IDLE;
            ST_POP_RET:    state_d = ST_POP_FLAGS;
            ST_POP_FLAGS:  state_d = ST_POP_TAKE;
            ST_POP_TAKE:   state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Outputs, a function of the state only (plus the idle arm decision)
    always_comb begin
        busy        = 1'b1;
        idle        = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        sp_dec      = 1'b0;
        sp_inc      = 1'b0;
        tf_clear    = 1'b0;
        fl_restore  = 1'b0;
        arm_sample  = 1'b0;
        redirect    = 1'b0;
        redirect_pc = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy       = 1'b0;
                idle       = 1'b1;
                arm_sample = insn_done && !ret_req && !armed;
            end
            ST_PUSH_FLAGS: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - STEP;
                mem_wdata = flags_q;
                sp_dec    = 1'b1;
                tf_clear  = 1'b1;
            end
            ST_PUSH_RET: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - STEP;
                mem_wdata = ret_pc;
                sp_dec    = 1'b1;
            end
            ST_VEC_READ: begin
                mem_rd   = 1'b1;
                mem_addr = VEC_ADDR;
            end
            ST_VEC_TAKE: begin
                redirect    = 1'b1;
                redirect_pc = mem_rdata;
                arm_sample  = 1'b1;
            end
            ST_POP_RET, ST_POP_FLAGS: begin
                mem_rd   = 1'b1;
                mem_addr = sp_q;
                sp_inc   = 1'b1;
            end
            ST_POP_TAKE: begin
                redirect    = 1'b1;
                redirect_pc = ret_pc;
                fl_restore  = 1'b1;
                arm_sample  = 1'b1;
            end
            default: busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/step_trap_seq.sv
module step_trap_seq
    import step_trap_pkg::*;
#(
    parameter logic [15:0] SP_RESET   = 16'h0100,
    parameter int          VEC_BASE   = 0,
    parameter int          VEC_INDEX  = 1,
    parameter int          VEC_BYTES  = 4,
    parameter int          WORD_BYTES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_done,
    input  logic [15:0] next_pc,
    input  logic        ret_req,
    input  logic        flags_ld,
    input  logic [15:0] flags_din,
    output logic [15:0] flags_q,
    output logic [15:0] sp_q,
    output logic        busy,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        redirect,
    output logic [15:0] redirect_pc
);
    localparam logic [WORD_W-1:0] VEC_ADDR = WORD_W'(VEC_BASE + VEC_INDEX * VEC_BYTES);

    seq_state_t ctrl_state;
    logic       armed_w, idle_w, sp_dec_w, sp_inc_w;
    logic       tf_clear_w, restore_w, arm_sample_w;

    tss_ctrl #(.VEC_ADDR(VEC_ADDR), .WORD_BYTES(WORD_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .ret_req    (ret_req),
        .armed      (armed_w),
        .next_pc    (next_pc),
        .flags_q    (flags_q),
        .sp_q       (sp_q),
        .mem_rdata  (mem_rdata),
        .state_o    (ctrl_state),
        .busy       (busy),
        .idle       (idle_w),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sp_dec     (sp_dec_w),
        .sp_inc     (sp_inc_w),
        .tf_clear   (tf_clear_w),
        .fl_restore (restore_w),
        .arm_sample (arm_sample_w),
        .redirect   (redirect),
        .redirect_pc(redirect_pc)
    );

    tss_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle_w),
        .ld         (flags_ld),
        .din        (flags_din),
        .tf_clear   (tf_clear_w),
        .restore    (restore_w),
        .restore_val(mem_rdata),
        .arm_sample (arm_sample_w),
        .flags_q    (flags_q),
        .armed      (armed_w)
    );

    tss_stack_ptr #(.SP_RESET(SP_RESET), .WORD_BYTES(WORD_BYTES)) u_sp (
        .clk  (clk),
        .rst_n(rst_n),
        .dec  (sp_dec_w),
        .inc  (sp_inc_w),
        .sp_q (sp_q)
    );
endmodule

// File: rtl/step_trap_seq_chk.sv
module step_trap_seq_chk
    import step_trap_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR = 16'd4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        ret_req,
    input logic        busy,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [15:0] mem_addr,
    input logic [15:0] flags_q,
    input logic [15:0] sp_q,
    input logic        redirect,
    input seq_state_t  state,
    input logic        armed
);
    p_push_flags_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && insn_done && !ret_req && armed)
        |=> (mem_wr && mem_addr == $past(sp_q) - 16'd2));

    p_tf_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_FLAGS) |=> !flags_q[TF_POS]);

    p_handler_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_TAKE) |=> !armed);

    p_vector_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_RET) |=> (mem_rd && mem_addr == VEC_ADDR));

    p_pop_from_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ret_req) |=> (mem_rd && mem_addr == $past(sp_q)));

    p_flags_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_PUSH_FLAGS && state != ST_POP_TAKE) |=> $stable(flags_q));

    p_single_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !redirect));

    p_redirect_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!redirect && !busy));
endmodule

bind step_trap_seq step_trap_seq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_done(insn_done),
    .ret_req  (ret_req),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .flags_q  (flags_q),
    .sp_q     (sp_q),
    .redirect (redirect),
    .state    (ctrl_state),
    .armed    (armed_w)
);

// File: tb/test_step_trap_seq.sv
`timescale 1ns/1ps
module test_step_trap_seq;
    localparam logic [15:0] KEEP = 16'h0FD5;
    localparam logic [15:0] TFM  = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, ret_req = 1'b0, flags_ld = 1'b0;
    logic [15:0] next_pc = '0, flags_din = '0;
    logic [15:0] flags_q, sp_q, mem_addr, mem_wdata, redirect_pc;
    logic [15:0] mem_rdata = '0;
    logic        busy, mem_rd, mem_wr, redirect;

    always #10 clk = ~clk;

    step_trap_seq i_step_trap_seq (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .next_pc(next_pc),
        .ret_req(ret_req), .flags_ld(flags_ld), .flags_din(flags_din),
        .flags_q(flags_q), .sp_q(sp_q), .busy(busy), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    // Simple word memory, read data one cycle after the strobe
    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[8:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[8:1]];
    end

    typedef struct packed {
        logic        busy, rd, wr;
        logic [15:0] addr, wdata;
        logic        redir;
        logic [15:0] rpc, flags, sp;
    } exp_t;

    exp_t        cur;
    exp_t        q[$];
    logic [15:0] m_flags = '0, m_sp = 16'h0100;
    logic        m_armed = 1'b0;
    string       tag = "R1";
    int          n_chk = 0, n_fail = 0, n_redir = 0;
    bit          finished = 0;

    function automatic exp_t mk(logic b, logic r, logic w, logic [15:0] a, logic [15:0] d,
                                logic rd_o, logic [15:0] p, logic [15:0] f, logic [15:0] s);
        exp_t e;
        e.busy = b; e.rd = r; e.wr = w; e.addr = a; e.wdata = d;
        e.redir = rd_o; e.rpc = p; e.flags = f; e.sp = s;
        return e;
    endfunction

    function automatic logic [15:0] peek(logic [15:0] a);
        return mem[a[8:1]];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: the outputs expected after the coming clock edge
    task automatic model_step();
        logic [15:0] s, f, v;
        if (q.size() > 0) begin
            cur = q.pop_front();
            return;
        end
        if (flags_ld) m_flags = flags_din & KEEP;
        s = m_sp; f = m_flags;
        if (ret_req) begin
            v = peek(16'(s + 16'd2));
            q.push_back(mk(1, 1, 0, s, 0, 0, 0, f, s));
            q.push_back(mk(1, 1, 0, 16'(s + 16'd2), 0, 0, 0, f, 16'(s + 16'd2)));
            q.push_back(mk(1, 0, 0, 0, 0, 1, peek(s), f, 16'(s + 16'd4)));
            m_flags = v & KEEP; m_sp = 16'(s + 16'd4); m_armed = v[8];
        end else if (insn_done && m_armed) begin
            v = peek(16'd4);
            q.push_back(mk(1, 0, 1, 16'(s - 16'd2), f, 0, 0, f, s));
            q.push_back(mk(1, 0, 1, 16'(s - 16'd4), next_pc, 0, 0, f & ~TFM, 16'(s - 16'd2)));
            q.push_back(mk(1, 1, 0, 16'd4, 0, 0, 0, f & ~TFM, 16'(s - 16'd4)));
            q.push_back(mk(1, 0, 0, 0, 0, 1, v, f & ~TFM, 16'(s - 16'd4)));
            m_flags = f & ~TFM; m_sp = 16'(s - 16'd4); m_armed = 1'b0;
        end else if (insn_done) begin
            m_armed = m_flags[8];
        end
        q.push_back(mk(0, 0, 0, 0, 0, 0, 0, m_flags, m_sp));
        cur = q.pop_front();
    endtask

    task automatic compare();
        logic bad;
        n_chk++;
        if (redirect) n_redir++;
        bad = (busy !== cur.busy) || (mem_rd !== cur.rd) || (mem_wr !== cur.wr) ||
              (redirect !== cur.redir) || (flags_q !== cur.flags) || (sp_q !== cur.sp) ||
              ((cur.rd || cur.wr) && mem_addr !== cur.addr) ||
              (cur.wr && mem_wdata !== cur.wdata) ||
              (cur.redir && redirect_pc !== cur.rpc);
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual busy=%b rd=%b wr=%b addr=%h wd=%h rdir=%b rpc=%h fl=%h sp=%h expected busy=%b rd=%b wr=%b addr=%h wd=%h rdir=%b rpc=%h fl=%h sp=%h",
                     tag, busy, mem_rd, mem_wr, mem_addr, mem_wdata, redirect, redirect_pc, flags_q, sp_q,
                     cur.busy, cur.rd, cur.wr, cur.addr, cur.wdata, cur.redir, cur.rpc, cur.flags, cur.sp);
        end
    endtask

    task automatic cyc(logic d, logic r, logic l, logic [15:0] din, logic [15:0] pc);
        insn_done = d; ret_req = r; flags_ld = l; flags_din = din; next_pc = pc;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, 16'h0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        int r0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0123) ^ 16'h5A5A;
        mem[2] = 16'h0300;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags", flags_q, 16'h0000);
        chk("R1 sp", sp_q, 16'h0100);
        chk("R1 quiet", {15'b0, busy | mem_rd | mem_wr | redirect}, 16'h0);

        tag = "R2 R7 no trap with bit clear";
        repeat (3) cyc(1, 0, 0, 16'h0, 16'h1000);
        tag = "R7 load mid instruction";
        cyc(0, 0, 1, 16'hF1FF, 16'h0);
        chk("R7 reserved bits cleared", flags_q, 16'h01D5);
        cyc(1, 0, 0, 16'h0, 16'h1232);
        chk("R7 loading instruction does not trap", {15'b0, busy}, 16'h0);
        tag = "R2 R3 R4 R8 trap entry";
        r0 = n_redir;
        cyc(1, 0, 0, 16'h0, 16'h1234);
        cyc(1, 1, 1, 16'h0000, 16'h9999);
        cyc(1, 0, 1, 16'hFFFF, 16'h9999);
        cyc(0, 1, 0, 16'h0, 16'h0);
        cyc(1, 1, 1, 16'h0000, 16'h0);
        chk("R4 one redirect", 16'(n_redir - r0), 16'd1);
        chk("R2 sp after entry", sp_q, 16'h00FC);
        chk("R2 pushed flags", peek(16'h00FE), 16'h01D5);
        chk("R2 pushed return", peek(16'h00FC), 16'h1234);
        chk("R3 bit cleared", flags_q, 16'h00D5);
        tag = "R3 handler unstepped";
        r0 = n_redir;
        repeat (3) cyc(1, 0, 0, 16'h0, 16'h0310);
        chk("R3 no handler trap", 16'(n_redir - r0), 16'd0);

        tag = "R5 return";
        cyc(0, 1, 0, 16'h0, 16'h0);
        idle_n(3);
        chk("R5 flags restored", flags_q, 16'h01D5);
        chk("R5 sp restored", sp_q, 16'h0100);
        tag = "R6 one instruction then trap";
        r0 = n_redir;
        cyc(1, 0, 0, 16'h0, 16'h1236);
        idle_n(4);
        chk("R6 trap after first boundary", 16'(n_redir - r0), 16'd1);
        chk("R6 return address", peek(16'h00FC), 16'h1236);

        tag = "R9 return wins over boundary";
        cyc(0, 0, 1, 16'h0100, 16'h0);
        cyc(1, 0, 0, 16'h0, 16'h0320);
        r0 = n_redir;
        cyc(1, 1, 0, 16'h0, 16'h0322);
        idle_n(3);
        chk("R9 only return redirect", 16'(n_redir - r0), 16'd1);
        chk("R9 sp after return", sp_q, 16'h0100);
        tag = "R7 clear during armed instruction";
        cyc(0, 0, 1, 16'h0000, 16'h0);
        r0 = n_redir;
        cyc(1, 0, 0, 16'h0, 16'h2000);
        idle_n(4);
        chk("R7 armed instruction still traps", 16'(n_redir - r0), 16'd1);
        chk("R7 pushed cleared flags", peek(16'h00FE), 16'h0000);
        tag = "R5 R10 return then free run";
        cyc(0, 1, 0, 16'h0, 16'h0);
        idle_n(3);
        r0 = n_redir;
        repeat (3) cyc(1, 0, 0, 16'h0, 16'h2002);
        chk("R5 no further traps", 16'(n_redir - r0), 16'd0);
        chk("R5 final flags", flags_q, 16'h0000);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule